// File: doc/BRIEF.md
# Congestion-Aware Mesh Route Selector

This block is the route computation stage of one switch in a two-dimensional mesh network-on-chip. When a head flit arrives, it takes the switch's own coordinates, the packet's destination coordinates, the free-slot counts reported by the four neighbouring switches and four row/column alarm wires. From these it names one output port: Local, East, West, North or South. Every route it picks is minimal, so each hop reduces the distance to the destination. When both coordinate offsets are nonzero, it chooses between the productive X and productive Y direction. Normally the neighbour with more free slots wins. When the remaining X or Y distance is exactly one hop, it also consults the row or column alarm wire, so that the packet can leave a congested or broken row or column while another minimal path still exists.

The block also drives this switch's share of the alarms. For each travel direction it raises a contribution bit when the switch's own input buffer for that direction holds more than a threshold, or when the link in that direction is marked failed. Outside the block, the contributions of every switch along a row or column are ORed together to form the wire that each switch reads.

Control is a two-state machine. ST_IDLE is the state with no result; a head flit (`head_valid` high at a clock edge) moves it to ST_RESULT. In ST_RESULT the captured request is presented, and the machine stays there while further head flits arrive on consecutive edges. When `head_valid` is low at an edge, it returns to ST_IDLE. Reset enters ST_IDLE.

Top module: `mesh_route_sel`

## Requirements
- R1: While `rst_n` is low, `route_valid` is 0, `route_port` is 0 and `alarm_out` is 0.
- R2: If `head_valid` is 1 at a rising edge, `route_valid` is 1 for the following cycle, and `route_port` is computed only from the inputs sampled at that edge. If `head_valid` is 0 at an edge, `route_valid` is 0 for the following cycle and `route_port` reads 0.
- R3: Port codes are Local=0, East=1, West=2, North=3, South=4; East means increasing X and North means increasing Y. A destination equal to the current coordinates gives Local.
- R4: If exactly one offset is zero, the single productive direction is chosen. Free counts and alarm wires cannot change this choice, even when the chosen direction is flagged.
- R5: If both offsets are nonzero and no one-hop flag decides the route, X is chosen when the free count of the productive X neighbour is greater than or equal to that of the productive Y neighbour; otherwise Y is chosen.
- R6: If both offsets are nonzero, the X offset is exactly one and the row wire for the productive X direction (`row_alarm_east` or `row_alarm_west`) is 1, while Y is not flagged under R7, the Y direction is chosen whatever the free counts are.
- R7: If both offsets are nonzero, the Y offset is exactly one and the column wire for the productive Y direction (`col_alarm_north` or `col_alarm_south`) is 1, while X is not flagged under R6, the X direction is chosen whatever the free counts are.
- R8: If X and Y are both flagged under R6 and R7, the free-count rule of R5 decides.
- R9: A row or column wire has no effect when the offset on its axis is two or more.
- R10: `alarm_out[d]` is 1 one cycle after an edge at which `own_occ` lane d (bits d*OCC_W upward) exceeded ALARM_THRESH or `link_fail[d]` was 1, and is 0 otherwise; the bit order is East=0, West=1, North=2, South=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_valid | input | 1 | Head flit present; request is captured at the edge |
| cur_x | input | X_W | This switch's X coordinate |
| cur_y | input | Y_W | This switch's Y coordinate |
| dst_x | input | X_W | Destination X coordinate |
| dst_y | input | Y_W | Destination Y coordinate |
| free_east | input | CNT_W | Free slots at the East neighbour |
| free_west | input | CNT_W | Free slots at the West neighbour |
| free_north | input | CNT_W | Free slots at the North neighbour |
| free_south | input | CNT_W | Free slots at the South neighbour |
| row_alarm_east | input | 1 | ORed row wire for eastward travel |
| row_alarm_west | input | 1 | ORed row wire for westward travel |
| col_alarm_north | input | 1 | ORed column wire for northward travel |
| col_alarm_south | input | 1 | ORed column wire for southward travel |
| own_occ | input | 4*OCC_W | Own input-buffer occupancy, one lane per direction |
| link_fail | input | 4 | Failed-link marks, one per direction |
| alarm_out | output | 4 | This switch's alarm contributions |
| route_valid | output | 1 | Result present this cycle |
| route_port | output | 3 | Selected output port code |

## Verification
The hardest situation to reach from the ports is a one-hop offset on one axis with exactly one of the two relevant wires raised. For that case, the free counts must favour the opposite choice, so that the override is visible in the result. Uniform random coordinates rarely produce it. The random stimulus therefore places the destination one hop away on each axis about half the time and raises each alarm wire with even odds. Directed cases then fix the exact override, both-flagged, two-hop and single-axis patterns with counts that argue against the expected port.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int NDIR  = 4;
    localparam int DIR_E = 0;
    localparam int DIR_W = 1;
    localparam int DIR_N = 2;
    localparam int DIR_S = 3;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4
    } port_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } rstate_e;

    typedef struct packed {
        logic pos;   // destination lies at a higher coordinate
        logic neg;   // destination lies at a lower coordinate
        logic one;   // distance on this axis is exactly one hop
    } axis_off_t;

endpackage

// File: rtl/mr_offset_calc.sv
module mr_offset_calc
    import mesh_route_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output axis_off_t    off
);
    localparam int DW = W + 1;

    logic [DW-1:0] up_dist;
    logic [DW-1:0] dn_dist;

    always_comb begin
        up_dist = {1'b0, dst} - {1'b0, cur};
        dn_dist = {1'b0, cur} - {1'b0, dst};
        off.pos = (dst > cur);
        off.neg = (dst < cur);
        off.one = (off.pos && up_dist == DW'(1)) || (off.neg && dn_dist == DW'(1));
    end
endmodule

// File: rtl/mr_port_pick.sv
module mr_port_pick
    import mesh_route_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  axis_off_t        xo,
    input  axis_off_t        yo,
    input  logic [CNT_W-1:0] free_e,
    input  logic [CNT_W-1:0] free_w,
    input  logic [CNT_W-1:0] free_n,
    input  logic [CNT_W-1:0] free_s,
    input  logic             row_e,
    input  logic             row_w,
    input  logic             col_n,
    input  logic             col_s,
    output port_e            pick
);
    logic             x_move;
    logic             y_move;
    port_e            x_dir;
    port_e            y_dir;
    logic [CNT_W-1:0] free_x;
    logic [CNT_W-1:0] free_y;
    logic             flag_x;
    logic             flag_y;

    always_comb begin
        x_move = xo.pos | xo.neg;
        y_move = yo.pos | yo.neg;
        x_dir  = xo.pos ? PORT_EAST  : PORT_WEST;
        y_dir  = yo.pos ? PORT_NORTH : PORT_SOUTH;
        free_x = xo.pos ? free_e : free_w;
        free_y = yo.pos ? free_n : free_s;
        // a wire only matters when its axis has a single hop left
        flag_x = xo.one & (xo.pos ? row_e : row_w);
        flag_y = yo.one & (yo.pos ? col_n : col_s);

        if (!x_move && !y_move) begin
            pick = PORT_LOCAL;
        end else if (!y_move) begin
            pick = x_dir;
        end else if (!x_move) begin
            pick = y_dir;
        end else if (flag_x && !flag_y) begin
            pick = y_dir;
        end else if (flag_y && !flag_x) begin
            pick = x_dir;
        end else if (free_x >= free_y) begin
            pick = x_dir;
        end else begin
            pick = y_dir;
        end
    end
endmodule

// File: rtl/mr_alarm_gen.sv
module mr_alarm_gen #(
    parameter int NDIR         = 4,
    parameter int OCC_W        = 4,
    parameter int ALARM_THRESH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NDIR*OCC_W-1:0] occ,
    input  logic [NDIR-1:0]       fail,
    output logic [NDIR-1:0]       alarm
);
    localparam logic [OCC_W-1:0] THR = OCC_W'(ALARM_THRESH);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        logic raise;
        assign raise = (occ[d*OCC_W +: OCC_W] > THR) | fail[d];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alarm[d] <= 1'b0;
            end else begin
                alarm[d] <= raise;
            end
        end
    end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
    import mesh_route_pkg::*;
#(
    parameter int X_W          = 3,
    parameter int Y_W          = 3,
    parameter int CNT_W        = 4,
    parameter int OCC_W        = 4,
    parameter int ALARM_THRESH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  head_valid,
    input  logic [X_W-1:0]        cur_x,
    input  logic [Y_W-1:0]        cur_y,
    input  logic [X_W-1:0]        dst_x,
    input  logic [Y_W-1:0]        dst_y,
    input  logic [CNT_W-1:0]      free_east,
    input  logic [CNT_W-1:0]      free_west,
    input  logic [CNT_W-1:0]      free_north,
    input  logic [CNT_W-1:0]      free_south,
    input  logic                  row_alarm_east,
    input  logic                  row_alarm_west,
    input  logic                  col_alarm_north,
    input  logic                  col_alarm_south,
    input  logic [4*OCC_W-1:0]    own_occ,
    input  logic [3:0]            link_fail,
    output logic [3:0]            alarm_out,
    output logic                  route_valid,
    output logic [2:0]            route_port
);
    rstate_e          state_q;
    rstate_e          state_d;

    logic [X_W-1:0]   cx_q, dx_q;
    logic [Y_W-1:0]   cy_q, dy_q;
    logic [CNT_W-1:0] fe_q, fw_q, fn_q, fs_q;
    logic             re_q, rw_q, cn_q, cs_q;

    axis_off_t        x_off;
    axis_off_t        y_off;
    port_e            pick;
    port_e            port_o;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (head_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!head_valid) state_d = ST_IDLE;
        endcase
    end

    // request capture on each head flit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx_q <= '0; cy_q <= '0; dx_q <= '0; dy_q <= '0;
            fe_q <= '0; fw_q <= '0; fn_q <= '0; fs_q <= '0;
            re_q <= 1'b0; rw_q <= 1'b0; cn_q <= 1'b0; cs_q <= 1'b0;
        end else if (head_valid) begin
            cx_q <= cur_x;      cy_q <= cur_y;
            dx_q <= dst_x;      dy_q <= dst_y;
            fe_q <= free_east;  fw_q <= free_west;
            fn_q <= free_north; fs_q <= free_south;
            re_q <= row_alarm_east;  rw_q <= row_alarm_west;
            cn_q <= col_alarm_north; cs_q <= col_alarm_south;
        end
    end

    mr_offset_calc #(.W(X_W)) u_xoff (.cur(cx_q), .dst(dx_q), .off(x_off));
    mr_offset_calc #(.W(Y_W)) u_yoff (.cur(cy_q), .dst(dy_q), .off(y_off));

    mr_port_pick #(.CNT_W(CNT_W)) u_pick (
        .xo     (x_off),
        .yo     (y_off),
        .free_e (fe_q),
        .free_w (fw_q),
        .free_n (fn_q),
        .free_s (fs_q),
        .row_e  (re_q),
        .row_w  (rw_q),
        .col_n  (cn_q),
        .col_s  (cs_q),
        .pick   (pick)
    );

    mr_alarm_gen #(
        .NDIR         (NDIR),
        .OCC_W        (OCC_W),
        .ALARM_THRESH (ALARM_THRESH)
    ) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .occ   (own_occ),
        .fail  (link_fail),
        .alarm (alarm_out)
    );

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   port_o = PORT_LOCAL;
            ST_RESULT: port_o = pick;
        endcase
    end

    assign route_valid = (state_q == ST_RESULT);
    assign route_port  = port_o;
endmodule

// File: rtl/mesh_route_sel_chk.sv
module mesh_route_sel_chk #(
    parameter int X_W   = 3,
    parameter int Y_W   = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           head_valid,
    input logic [X_W-1:0] cur_x,
    input logic [Y_W-1:0] cur_y,
    input logic [X_W-1:0] dst_x,
    input logic [Y_W-1:0] dst_y,
    input logic [3:0]     link_fail,
    input logic [3:0]     alarm_out,
    input logic           route_valid,
    input logic [2:0]     route_port
);
    assert_valid_needs_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> $past(head_valid));

    assert_head_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |=> route_valid);

    assert_idle_port_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !route_valid |-> route_port == 3'd0);

    assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        route_port <= 3'd4);

    assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && cur_x == dst_x && cur_y == dst_y) |=> route_port == 3'd0);

    assert_x_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && cur_y == dst_y && dst_x > cur_x) |=> route_port == 3'd1);

    assert_y_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && cur_x == dst_x && dst_y < cur_y) |=> route_port == 3'd4);

    assert_minimal_east_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && dst_x > cur_x) |=> route_port != 3'd2);

    assert_fail_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (alarm_out & $past(link_fail)) == $past(link_fail));
endmodule

bind mesh_route_sel mesh_route_sel_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_valid  (head_valid),
    .cur_x       (cur_x),
    .cur_y       (cur_y),
    .dst_x       (dst_x),
    .dst_y       (dst_y),
    .link_fail   (link_fail),
    .alarm_out   (alarm_out),
    .route_valid (route_valid),
    .route_port  (route_port)
);

// File: tb/test_mesh_route_sel.sv
`timescale 1ns/1ps
module test_mesh_route_sel;
    localparam int X_W = 3, Y_W = 3, CNT_W = 4, OCC_W = 4, THR = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             head_valid = 1'b0;
    logic [X_W-1:0]   cur_x = '0, dst_x = '0;
    logic [Y_W-1:0]   cur_y = '0, dst_y = '0;
    logic [CNT_W-1:0] free_east = '0, free_west = '0, free_north = '0, free_south = '0;
    logic             row_alarm_east = 0, row_alarm_west = 0;
    logic             col_alarm_north = 0, col_alarm_south = 0;
    logic [4*OCC_W-1:0] own_occ = '0;
    logic [3:0]       link_fail = '0;
    logic [3:0]       alarm_out;
    logic             route_valid;
    logic [2:0]       route_port;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mesh_route_sel #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .OCC_W(OCC_W),
                     .ALARM_THRESH(THR)) i_mesh_route_sel (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .free_east(free_east), .free_west(free_west),
        .free_north(free_north), .free_south(free_south),
        .row_alarm_east(row_alarm_east), .row_alarm_west(row_alarm_west),
        .col_alarm_north(col_alarm_north), .col_alarm_south(col_alarm_south),
        .own_occ(own_occ), .link_fail(link_fail), .alarm_out(alarm_out),
        .route_valid(route_valid), .route_port(route_port)
    );

    function automatic int exp_port(int cx, int cy, int tx, int ty,
                                    int fe, int fw, int fn, int fs,
                                    bit re, bit rw, bit cn, bit cs);
        int ox = tx - cx, oy = ty - cy;
        int xd = (ox > 0) ? 1 : 2;
        int yd = (oy > 0) ? 3 : 4;
        bit flx = (ox == 1 && re) || (ox == -1 && rw);
        bit fly = (oy == 1 && cn) || (oy == -1 && cs);
        int fx = (ox > 0) ? fe : fw;
        int fy = (oy > 0) ? fn : fs;
        if (ox == 0 && oy == 0) return 0;
        if (oy == 0) return xd;
        if (ox == 0) return yd;
        if (flx && !fly) return yd;
        if (fly && !flx) return xd;
        return (fx >= fy) ? xd : yd;
    endfunction

    function automatic string rule_tag(int cx, int cy, int tx, int ty,
                                       bit re, bit rw, bit cn, bit cs);
        int ox = tx - cx, oy = ty - cy;
        bit flx = (ox == 1 && re) || (ox == -1 && rw);
        bit fly = (oy == 1 && cn) || (oy == -1 && cs);
        if (ox == 0 && oy == 0) return "R3";
        if (ox == 0 || oy == 0) return "R4";
        if (flx && !fly) return "R6";
        if (fly && !flx) return "R7";
        if (flx && fly) return "R8";
        if (re || rw || cn || cs) return "R9";
        return "R5";
    endfunction

    function automatic logic [3:0] exp_alarm(logic [4*OCC_W-1:0] occ, logic [3:0] lf);
        logic [3:0] a;
        for (int d = 0; d < 4; d++) a[d] = (int'(occ[d*OCC_W +: OCC_W]) > THR) || lf[d];
        return a;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // caller is at a negedge; drive, wait one cycle, check
    task automatic run_case(int cx, int cy, int tx, int ty,
                            int fe, int fw, int fn, int fs,
                            bit re, bit rw, bit cn, bit cs,
                            logic [4*OCC_W-1:0] occ, logic [3:0] lf);
        int ep;
        logic [3:0] ea;
        cur_x = X_W'(cx); cur_y = Y_W'(cy); dst_x = X_W'(tx); dst_y = Y_W'(ty);
        free_east = CNT_W'(fe); free_west = CNT_W'(fw);
        free_north = CNT_W'(fn); free_south = CNT_W'(fs);
        row_alarm_east = re; row_alarm_west = rw;
        col_alarm_north = cn; col_alarm_south = cs;
        own_occ = occ; link_fail = lf; head_valid = 1'b1;
        ep = exp_port(cx, cy, tx, ty, fe, fw, fn, fs, re, rw, cn, cs);
        ea = exp_alarm(occ, lf);
        @(negedge clk);
        // scramble live inputs: result must come from the sampled edge (R2)
        free_east = ~free_east; row_alarm_east = ~row_alarm_east;
        check("R2 valid", int'(route_valid), 1);
        check(rule_tag(cx, cy, tx, ty, re, rw, cn, cs), int'(route_port), ep);
        check("R10 alarm", int'(alarm_out), int'(ea));
    endtask

    task automatic idle_case();
        head_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", int'(route_valid), 0);
        check("R2 idle port", int'(route_port), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cx, cy, tx, ty;
        void'($urandom(32'd20240611));
        // reset with busy inputs
        head_valid = 1'b1; link_fail = 4'hF; own_occ = '1;
        repeat (3) @(negedge clk);
        check("R1 valid", int'(route_valid), 0);
        check("R1 port", int'(route_port), 0);
        check("R1 alarm", int'(alarm_out), 0);
        head_valid = 1'b0; link_fail = '0; own_occ = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_case();

        // R3 local
        run_case(3, 3, 3, 3, 1, 9, 9, 9, 1, 1, 1, 1, '0, 4'h0);
        // R4 single axis, flagged and starved direction still taken
        run_case(2, 4, 3, 4, 0, 15, 15, 15, 1, 0, 1, 1, '0, 4'h1);
        run_case(5, 4, 5, 3, 15, 15, 15, 0, 1, 1, 1, 1, '0, 4'h8);
        run_case(6, 1, 0, 1, 0, 0, 9, 9, 1, 1, 0, 0, '0, 4'h2);
        // R5 counts: tie goes X, then Y wins
        run_case(1, 1, 4, 5, 7, 0, 7, 0, 0, 0, 0, 0, {4'd0, 4'd0, 4'd0, 4'd13}, 4'h0);
        run_case(4, 5, 1, 1, 0, 3, 0, 4, 0, 0, 0, 0, {4'd12, 4'd0, 4'd0, 4'd0}, 4'h0);
        // R6 X one hop flagged, counts favour X
        run_case(2, 2, 3, 5, 15, 0, 1, 0, 1, 0, 0, 0, '0, 4'h4);
        run_case(2, 2, 1, 0, 0, 15, 0, 1, 0, 1, 0, 0, '0, 4'h0);
        // R7 Y one hop flagged, counts favour Y
        run_case(2, 2, 5, 3, 1, 0, 15, 0, 0, 0, 1, 0, '0, 4'h0);
        run_case(5, 5, 0, 4, 0, 2, 0, 15, 0, 0, 0, 1, '0, 4'h0);
        // R8 both flagged, counts decide
        run_case(2, 2, 3, 3, 2, 0, 9, 0, 1, 0, 1, 0, '0, 4'h0);
        run_case(2, 2, 1, 1, 0, 9, 0, 9, 0, 1, 0, 1, '0, 4'h0);
        // R9 two-hop offsets ignore wires
        run_case(1, 1, 3, 4, 9, 0, 2, 0, 1, 1, 1, 1, '0, 4'h0);
        run_case(1, 1, 4, 2, 2, 0, 9, 0, 1, 1, 0, 0, '0, 4'h0);
        // wrong-direction wires do not count as flags (R6)
        run_case(2, 2, 3, 4, 9, 0, 2, 0, 0, 1, 0, 1, '0, 4'h0);
        idle_case();

        for (int i = 0; i < 600; i++) begin
            cx = $urandom_range(0, 7); cy = $urandom_range(0, 7);
            tx = $urandom_range(0, 7); ty = $urandom_range(0, 7);
            if ($urandom_range(0, 1) == 1) tx = (cx == 7) ? 6 : ((cx == 0) ? 1 : cx + ($urandom_range(0, 1) == 1 ? 1 : -1));
            if ($urandom_range(0, 1) == 1) ty = (cy == 7) ? 6 : ((cy == 0) ? 1 : cy + ($urandom_range(0, 1) == 1 ? 1 : -1));
            run_case(cx, cy, tx, ty,
                     $urandom_range(0, 15), $urandom_range(0, 15),
                     $urandom_range(0, 15), $urandom_range(0, 15),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     16'($urandom), 4'($urandom_range(0, 15)));
            if (i % 9 == 8) idle_case();
        end
        idle_case();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule